// File: doc/BRIEF.md
# Hot-Plug Device Bay Status and State Controller

This block holds the status word and the hardware state machine for two hot-plug device bays. Each bay has four active-low pins: a removal-request button, a security lock, a 1394 presence detect and a USB presence detect. Every pin passes through a two-flop synchronizer before any edge is detected. Presence edges record a sticky status-change event. A falling edge of the button records a sticky removal-request event. With the matching enables from the companion control register, these events also move the bay's state.

A host reads each bay's status word through a plain 32-bit register port. The port has a combinational read and a single-cycle write strobe. Bay 0 sits at offset 0x14 and bay 1 at 0x20. The two sticky bits are cleared by writing ones to their positions. The form-factor field accepts exactly one write after power-on. A later plain reset neither clears it nor re-opens it. The alert output is a level: it is high while any sticky bit is set whose enable is also set.

Bay states, with their codes in bits 6:4:
- EMPTY (000)
- INSERTED (001)
- ENABLED (010)
- REM_REQ (011)
- REM_OK (100)

Hardware produces these transitions:
- insertion with status-change enable: any state to INSERTED.
- button with removal-request enable: any occupied state to REM_OK.
- button without that enable: any occupied state to REM_REQ.
- last presence bit dropping: any state to EMPTY.

When events coincide, EMPTY wins over the button, and the button wins over insertion. ENABLED is entered only by software, which lies outside this block.

Top module: `bay_status_ctrl`

## Requirements
- R1: Bits 31:11 of a bay's status word always read 0, and a read of any offset other than 0x14 or 0x20 returns 0.
- R2: When `rst_n` or `por_n` is low, each bay's state (bits 6:4) becomes 000, both sticky bits (3 and 2) become 0, the synchronized pin bits become 0, and `alert` becomes 0.
- R3: The first write to a bay's offset after power-on stores `reg_wdata[10:8]` into bits 10:8. Every later write leaves those bits unchanged.
- R4: A pulse on `rst_n` neither changes bits 10:8 nor re-enables their write. Only a `por_n` pulse re-enables the write, and it keeps the stored value until that write occurs.
- R5: Bit 7 reads 0 while that bay's `seclock_en` is 0. Otherwise it reads the inverse of the synchronized `secure_n` pin.
- R6: Bit 1 reads the inverse of the synchronized `pr1394_n` pin, and bit 0 reads the inverse of the synchronized `prusb_n` pin. A pin change reaches the bits two clock edges later.
- R7: Bit 3 sets on a falling edge of the synchronized `remreq_n`. Writing 1 to bit 3 clears it, writing 0 leaves it, and a new set wins over a clear in the same cycle.
- R8: Bit 2 sets when either presence bit rises or falls, with one exception: a fall while the state is REM_OK (100) and `remwake_en` is 0 does not set it. Writing 1 to bit 2 clears it, and writing 0 leaves it.
- R9: A presence rise with `chg_en` set moves the state to INSERTED (001). Without `chg_en` the state is unchanged. The state never takes a code above 100.
- R10: A button event in a state other than EMPTY moves the state to REM_OK (100) if `remreq_en` is set, and to REM_REQ (011) if it is not. In EMPTY, the event changes no state.
- R11: When the last set presence bit falls, the state becomes EMPTY (000), overriding any other event in that cycle. The fall of one presence bit while the other stays set does not change the state.
- R12: `alert` is high exactly while some bay has bit 3 set with `remreq_en` set, or bit 2 set with `chg_en` set.
- R13: Each bay has its own pins, enables and status word. A write to one bay's offset has no effect on the other bay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; leaves the form-factor field and its write-once status untouched |
| por_n | input | 1 | Asynchronous active-low power-on reset; also re-enables the form-factor write |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| remreq_n | input | 2 | Removal-request button per bay, active low |
| secure_n | input | 2 | Security lock per bay, active low |
| pr1394_n | input | 2 | 1394 presence per bay, active low |
| prusb_n | input | 2 | USB presence per bay, active low |
| seclock_en | input | 2 | Per-bay enable that lets bit 7 show the lock |
| remreq_en | input | 2 | Per-bay removal-request interrupt enable |
| chg_en | input | 2 | Per-bay status-change interrupt enable |
| remwake_en | input | 2 | Per-bay enable for recording removals made from REM_OK |
| alert | output | 1 | Level alert for enabled sticky events |

## Verification
The hardest situation to reach is the exception in R8: a removal that must leave bit 2 clear. It occurs only when the bay is already in REM_OK and `remwake_en` is 0. From the ports, the stimulus first inserts a device with the status-change enable set. It then clears the sticky bits and presses the button with the removal-request enable set, so that the bay reaches REM_OK. Only then does it release the presence pin. The same path is repeated with `remwake_en` set, to show the bit does set there. A partial removal, with one of two presence pins dropped, shows the difference between a status-change event and a return to EMPTY. A button press on an empty bay shows the sticky bit setting while the state stays put.

// File: rtl/bay_pkg.sv
package bay_pkg;

    localparam int NUM_BAYS   = 2;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int FF_W       = 3;
    localparam int ST_W       = 3;
    localparam int PIN_W      = 4;
    localparam int SYNC_DEPTH = 2;

    // status word field positions
    localparam int BIT_USB    = 0;
    localparam int BIT_1394   = 1;
    localparam int BIT_CHG    = 2;
    localparam int BIT_RR     = 3;
    localparam int ST_LO      = 4;
    localparam int BIT_SEC    = 7;
    localparam int FF_LO      = 8;
    localparam int USED_W     = FF_LO + FF_W;

    // synchronized pin vector positions (active high after inversion)
    localparam int PIN_USB    = 0;
    localparam int PIN_1394   = 1;
    localparam int PIN_SEC    = 2;
    localparam int PIN_RR     = 3;

    typedef enum logic [ST_W-1:0] {
        ST_EMPTY    = 3'd0,
        ST_INSERTED = 3'd1,
        ST_ENABLED  = 3'd2,
        ST_REM_REQ  = 3'd3,
        ST_REM_OK   = 3'd4
    } bay_state_e;

    function automatic logic [ADDR_W-1:0] bay_offset(input int idx);
        return (idx == 0) ? ADDR_W'('h14) : ADDR_W'('h20);
    endfunction

endpackage

// File: rtl/bay_sync.sv
module bay_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                stg[i] <= stg[i-1];
            end
            stg[0] <= d;
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/bay_ffield.sv
module bay_ffield #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wval,
    output logic [W-1:0] val
);

    logic done_q;
    logic take;

    assign take = wr_hit && !done_q;

    // write-once status: only power-on clears it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            done_q <= 1'b0;
        end else if (take) begin
            done_q <= 1'b1;
        end
    end

    // value holds through every reset
    always_ff @(posedge clk) begin
        if (take) begin
            val <= wval;
        end
    end

endmodule

// File: rtl/bay_unit.sv
module bay_unit
    import bay_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [PIN_W-1:0]  pins_n,
    input  logic              seclock_en,
    input  logic              remreq_en,
    input  logic              chg_en,
    input  logic              remwake_en,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic [ST_W-1:0]   st_code,
    output logic [1:0]        pres_o,
    output logic              rr_sts,
    output logic              chg_sts,
    output logic [FF_W-1:0]   ff_o
);

    logic [PIN_W-1:0] sy;
    logic [1:0]       pres, pres_q;
    logic             rr_q;
    logic             ins_ev, rem_ev, gone_ev, btn_ev, chg_set;
    logic             clr_rr, clr_chg;
    bay_state_e       st_q, st_d;

    bay_sync #(.W(PIN_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (~pins_n),
        .q     (sy)
    );

    bay_ffield #(.W(FF_W)) u_ff (
        .clk    (clk),
        .por_n  (por_n),
        .wr_hit (wr_hit),
        .wval   (wdata[FF_LO +: FF_W]),
        .val    (ff_o)
    );

    assign pres = {sy[PIN_1394], sy[PIN_USB]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pres_q <= '0;
            rr_q   <= 1'b0;
        end else begin
            pres_q <= pres;
            rr_q   <= sy[PIN_RR];
        end
    end

    assign ins_ev  = |(pres & ~pres_q);
    assign rem_ev  = |(pres_q & ~pres);
    assign gone_ev = rem_ev && (pres == 2'b00);
    assign btn_ev  = sy[PIN_RR] && !rr_q;
    assign chg_set = ins_ev || (rem_ev && !((st_q == ST_REM_OK) && !remwake_en));
    assign clr_rr  = wr_hit && wdata[BIT_RR];
    assign clr_chg = wr_hit && wdata[BIT_CHG];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: EMPTY on last removal, then button, then insertion
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: begin
                if (ins_ev && chg_en) begin
                    st_d = ST_INSERTED;
                end
            end
            ST_INSERTED, ST_ENABLED, ST_REM_REQ, ST_REM_OK: begin
                if (gone_ev) begin
                    st_d = ST_EMPTY;
                end else if (btn_ev) begin
                    st_d = remreq_en ? ST_REM_OK : ST_REM_REQ;
                end else if (ins_ev && chg_en) begin
                    st_d = ST_INSERTED;
                end
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    // sticky event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_sts  <= 1'b0;
            chg_sts <= 1'b0;
        end else begin
            rr_sts  <= btn_ev  || (rr_sts  && !clr_rr);
            chg_sts <= chg_set || (chg_sts && !clr_chg);
        end
    end

    always_comb begin
        rd_word                   = '0;
        rd_word[BIT_USB]          = sy[PIN_USB];
        rd_word[BIT_1394]         = sy[PIN_1394];
        rd_word[BIT_CHG]          = chg_sts;
        rd_word[BIT_RR]           = rr_sts;
        rd_word[ST_LO +: ST_W]    = st_q;
        rd_word[BIT_SEC]          = seclock_en && sy[PIN_SEC];
        rd_word[FF_LO +: FF_W]    = ff_o;
    end

    assign st_code = st_q;
    assign pres_o  = pres;

endmodule

// File: rtl/bay_status_ctrl.sv
module bay_status_ctrl
    import bay_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_BAYS-1:0] remreq_n,
    input  logic [NUM_BAYS-1:0] secure_n,
    input  logic [NUM_BAYS-1:0] pr1394_n,
    input  logic [NUM_BAYS-1:0] prusb_n,
    input  logic [NUM_BAYS-1:0] seclock_en,
    input  logic [NUM_BAYS-1:0] remreq_en,
    input  logic [NUM_BAYS-1:0] chg_en,
    input  logic [NUM_BAYS-1:0] remwake_en,
    output logic                alert
);

    logic                             rst_all_n;
    logic [NUM_BAYS-1:0]              wr_hit;
    logic [NUM_BAYS-1:0]              rd_hit;
    logic [NUM_BAYS-1:0][DATA_W-1:0]  word_w;
    logic [NUM_BAYS-1:0][ST_W-1:0]    st_w;
    logic [NUM_BAYS-1:0][1:0]         pres_w;
    logic [NUM_BAYS-1:0][FF_W-1:0]    ff_w;
    logic [NUM_BAYS-1:0]              rr_sts;
    logic [NUM_BAYS-1:0]              chg_sts;

    assign rst_all_n = rst_n & por_n;

    for (genvar b = 0; b < NUM_BAYS; b++) begin : g_bay
        assign rd_hit[b] = (reg_addr == bay_offset(b));
        assign wr_hit[b] = reg_wr && rd_hit[b];

        bay_unit u_bay (
            .clk        (clk),
            .rst_n      (rst_all_n),
            .por_n      (por_n),
            .pins_n     ({remreq_n[b], secure_n[b], pr1394_n[b], prusb_n[b]}),
            .seclock_en (seclock_en[b]),
            .remreq_en  (remreq_en[b]),
            .chg_en     (chg_en[b]),
            .remwake_en (remwake_en[b]),
            .wr_hit     (wr_hit[b]),
            .wdata      (reg_wdata),
            .rd_word    (word_w[b]),
            .st_code    (st_w[b]),
            .pres_o     (pres_w[b]),
            .rr_sts     (rr_sts[b]),
            .chg_sts    (chg_sts[b]),
            .ff_o       (ff_w[b])
        );
    end

    always_comb begin
        reg_rdata = '0;
        alert     = 1'b0;
        for (int b = 0; b < NUM_BAYS; b++) begin
            if (rd_hit[b]) begin
                reg_rdata = reg_rdata | word_w[b];
            end
            alert = alert | (rr_sts[b] & remreq_en[b]) | (chg_sts[b] & chg_en[b]);
        end
    end

endmodule

// File: rtl/bay_status_chk.sv
module bay_status_chk
    import bay_pkg::*;
(
    input logic                           clk,
    input logic                           rst_n,
    input logic                           por_n,
    input logic [ADDR_W-1:0]              reg_addr,
    input logic [DATA_W-1:0]              reg_wdata,
    input logic [DATA_W-1:0]              reg_rdata,
    input logic [NUM_BAYS-1:0]            seclock_en,
    input logic [NUM_BAYS-1:0]            remreq_en,
    input logic [NUM_BAYS-1:0]            chg_en,
    input logic                           alert,
    input logic [NUM_BAYS-1:0]            wr_hit,
    input logic [NUM_BAYS-1:0][ST_W-1:0]  st_w,
    input logic [NUM_BAYS-1:0][1:0]       pres_w,
    input logic [NUM_BAYS-1:0][FF_W-1:0]  ff_w,
    input logic [NUM_BAYS-1:0]            rr_sts,
    input logic [NUM_BAYS-1:0]            chg_sts
);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        reg_rdata[DATA_W-1:USED_W] == '0);

    assert_alert_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        alert |-> ((remreq_en | chg_en) != '0));

    for (genvar b = 0; b < NUM_BAYS; b++) begin : g_chk
        assert_lock_masked_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            (!seclock_en[b] && reg_addr == bay_offset(b)) |-> !reg_rdata[BIT_SEC]);

        assert_ff_holds_R3: assert property (@(posedge clk) disable iff (!por_n)
            !$past(wr_hit[b]) |-> $stable(ff_w[b]));

        assert_rr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            (rr_sts[b] && !(wr_hit[b] && reg_wdata[BIT_RR])) |=> rr_sts[b]);

        assert_chg_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            (chg_sts[b] && !(wr_hit[b] && reg_wdata[BIT_CHG])) |=> chg_sts[b]);

        assert_state_legal_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            st_w[b] <= ST_W'(ST_REM_OK));

        assert_button_allowed_R10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            ($rose(rr_sts[b]) && $past(remreq_en[b]) && $past(pres_w[b]) != 2'b00
             && $past(st_w[b]) != ST_W'(ST_EMPTY)) |-> st_w[b] == ST_W'(ST_REM_OK));

        assert_empty_on_removal_R11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            (pres_w[b] != 2'b00) ##1 (pres_w[b] == 2'b00) |=> st_w[b] == ST_W'(ST_EMPTY));

        assert_alert_rr_R12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            (rr_sts[b] && remreq_en[b]) |-> alert);

        assert_alert_chg_R12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            (chg_sts[b] && chg_en[b]) |-> alert);
    end

endmodule

bind bay_status_ctrl bay_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .seclock_en (seclock_en),
    .remreq_en  (remreq_en),
    .chg_en     (chg_en),
    .alert      (alert),
    .wr_hit     (wr_hit),
    .st_w       (st_w),
    .pres_w     (pres_w),
    .ff_w       (ff_w),
    .rr_sts     (rr_sts),
    .chg_sts    (chg_sts)
);

// File: tb/bay_status_ctrl_test.sv
module bay_status_ctrl_test;
    import bay_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic [7:0]  reg_addr = 8'h14;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  remreq_n = 2'b11, secure_n = 2'b11, pr1394_n = 2'b11, prusb_n = 2'b11;
    logic [1:0]  seclock_en = '0, remreq_en = '0, chg_en = '0, remwake_en = '0;
    logic        alert;

    int n_chk = 0, n_fail = 0, addr_sel = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bay_status_ctrl uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .remreq_n(remreq_n),
        .secure_n(secure_n), .pr1394_n(pr1394_n), .prusb_n(prusb_n),
        .seclock_en(seclock_en), .remreq_en(remreq_en), .chg_en(chg_en),
        .remwake_en(remwake_en), .alert(alert)
    );

    // ---------------- behavioural reference model ----------------
    bit [3:0] m_s1 [2];     // {button, lock, 1394, usb}, active high
    bit [3:0] m_s2 [2];
    bit [1:0] m_prev [2];
    bit       m_btnq [2];
    int       m_st [2];
    bit       m_rr [2], m_chg [2];
    bit [2:0] m_ff [2];
    bit       m_ffdone [2], m_ffknown [2];

    task automatic model_clear();
        for (int b = 0; b < 2; b++) begin
            m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0; m_btnq[b] = 0;
            m_st[b] = 0; m_rr[b] = 0; m_chg[b] = 0;
        end
    endtask

    always @(posedge clk or negedge rst_n or negedge por_n) begin
        if (!por_n) begin
            model_clear();
            for (int b = 0; b < 2; b++) m_ffdone[b] = 0;
        end else if (!rst_n) begin
            model_clear();
        end else begin
            for (int b = 0; b < 2; b++) begin
                bit [1:0] now;
                bit ins, rem, gone, btn, hit;
                int ns;
                now  = m_s2[b][1:0];
                ins  = (now & ~m_prev[b]) != 0;
                rem  = (m_prev[b] & ~now) != 0;
                gone = rem && now == 0;
                btn  = m_s2[b][3] && !m_btnq[b];
                hit  = reg_wr && reg_addr == (b == 0 ? 8'h14 : 8'h20);
                ns   = m_st[b];
                if (m_st[b] == 0) begin
                    if (ins && chg_en[b]) ns = 1;
                end else if (gone) ns = 0;
                else if (btn) ns = remreq_en[b] ? 4 : 3;
                else if (ins && chg_en[b]) ns = 1;
                m_chg[b] = (ins || (rem && !(m_st[b] == 4 && !remwake_en[b])))
                           || (m_chg[b] && !(hit && reg_wdata[2]));
                m_rr[b]  = btn || (m_rr[b] && !(hit && reg_wdata[3]));
                m_st[b]  = ns;
                if (hit && !m_ffdone[b]) begin
                    m_ff[b] = reg_wdata[10:8]; m_ffdone[b] = 1; m_ffknown[b] = 1;
                end
                m_prev[b] = now;
                m_btnq[b] = m_s2[b][3];
                m_s2[b]   = m_s1[b];
                m_s1[b]   = ~{remreq_n[b], secure_n[b], pr1394_n[b], prusb_n[b]};
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && por_n && !done) begin
            int b;
            bit exp_alert;
            b = (reg_addr == 8'h14) ? 0 : (reg_addr == 8'h20) ? 1 : -1;
            if (b < 0) begin
                chk(reg_rdata == 0, "R1 unmapped offset", reg_rdata, 0);
            end else begin
                chk(reg_rdata[31:11] == 0, "R1 reserved bits", reg_rdata, 0);
                if (m_ffknown[b]) chk(reg_rdata[10:8] == m_ff[b], "R3 form factor", reg_rdata[10:8], m_ff[b]);
                chk(reg_rdata[7] == (seclock_en[b] & m_s2[b][2]), "R5 lock bit", reg_rdata[7], seclock_en[b] & m_s2[b][2]);
                chk(reg_rdata[6:4] == m_st[b], "R9 bay state", reg_rdata[6:4], m_st[b]);
                chk(reg_rdata[3] == m_rr[b], "R7 removal sticky", reg_rdata[3], m_rr[b]);
                chk(reg_rdata[2] == m_chg[b], "R8 change sticky", reg_rdata[2], m_chg[b]);
                chk(reg_rdata[1:0] == m_s2[b][1:0], "R6 presence", reg_rdata[1:0], m_s2[b][1:0]);
            end
            exp_alert = 0;
            for (int i = 0; i < 2; i++)
                exp_alert |= (m_rr[i] & remreq_en[i]) | (m_chg[i] & chg_en[i]);
            chk(alert == exp_alert, "R12 alert level", alert, exp_alert);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #5;
        addr_sel = (addr_sel + 1) % 3;
        reg_addr = (addr_sel == 0) ? 8'h14 : (addr_sel == 1) ? 8'h20 : 8'h18;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #5;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #5;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] w);
        @(posedge clk); #5;
        reg_addr = a;
        @(negedge clk);
        w = reg_rdata;
        @(posedge clk); #5;
    endtask

    task automatic press(input int b);
        remreq_n[b] = 1'b0; idle(4);
        remreq_n[b] = 1'b1; idle(3);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        for (int b = 0; b < 2; b++) begin m_ffknown[b] = 0; m_ffdone[b] = 0; end
        model_clear();
        idle(3);
        rst_n = 1'b1; por_n = 1'b1;
        idle(1);
        // R2: reset state
        rd(8'h14, w); chk((w & ~32'h700) == 0, "R2 bay0 after reset", w & ~32'h700, 0);
        rd(8'h20, w); chk((w & ~32'h700) == 0, "R2 bay1 after reset", w & ~32'h700, 0);
        chk(alert == 0, "R2 alert after reset", alert, 0);

        // R3: write once
        wr(8'h14, 32'h200); wr(8'h20, 32'h100);
        rd(8'h14, w); chk(w[10:8] == 3'd2, "R3 first write", w[10:8], 2);
        wr(8'h14, 32'h700);
        rd(8'h14, w); chk(w[10:8] == 3'd2, "R3 second write ignored", w[10:8], 2);

        // R4: survives plain reset, re-armed by power-on
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        wr(8'h14, 32'h500);
        rd(8'h14, w); chk(w[10:8] == 3'd2, "R4 plain reset keeps lock", w[10:8], 2);
        por_n = 1'b0; idle(2); por_n = 1'b1; idle(1);
        rd(8'h14, w); chk(w[10:8] == 3'd2, "R4 value kept over power-on", w[10:8], 2);
        wr(8'h14, 32'h000); wr(8'h20, 32'h100);
        rd(8'h14, w); chk(w[10:8] == 3'd0, "R4 write after power-on", w[10:8], 0);

        // R9 / R8 / R6 / R12: insertion on bay 0
        chg_en[0] = 1'b1; seclock_en[0] = 1'b1; prusb_n[0] = 1'b0; idle(4);
        rd(8'h14, w);
        chk(w[6:4] == 3'd1, "R9 inserted", w[6:4], 1);
        chk(w[2] == 1'b1, "R8 insertion sets change", w[2], 1);
        chk(w[1:0] == 2'b01, "R6 usb presence", w[1:0], 1);
        chk(alert == 1'b1, "R12 alert on change", alert, 1);

        // R5: lock bit
        secure_n[0] = 1'b0; idle(3);
        rd(8'h14, w); chk(w[7] == 1'b1, "R5 lock shown", w[7], 1);
        seclock_en[0] = 1'b0; idle(1);
        rd(8'h14, w); chk(w[7] == 1'b0, "R5 lock masked", w[7], 0);

        // R8: write-one-to-clear
        wr(8'h14, 32'h0);
        rd(8'h14, w); chk(w[2] == 1'b1, "R8 write zero no effect", w[2], 1);
        wr(8'h14, 32'h4);
        rd(8'h14, w); chk(w[2] == 1'b0, "R8 write one clears", w[2], 0);
        chk(alert == 1'b0, "R12 alert drops", alert, 0);

        // R7 / R10: button without enable
        press(0);
        rd(8'h14, w);
        chk(w[3] == 1'b1, "R7 button sets sticky", w[3], 1);
        chk(w[6:4] == 3'd3, "R10 removal requested", w[6:4], 3);
        chk(alert == 1'b0, "R12 no alert without enable", alert, 0);
        wr(8'h14, 32'h8);
        rd(8'h14, w); chk(w[3] == 1'b0, "R7 cleared", w[3], 0);

        // R10: button with enable
        remreq_en[0] = 1'b1; press(0);
        rd(8'h14, w); chk(w[6:4] == 3'd4, "R10 removal allowed", w[6:4], 4);
        chk(alert == 1'b1, "R12 alert on button", alert, 1);

        // R11 / R8 exception
        wr(8'h14, 32'h8);
        prusb_n[0] = 1'b1; idle(4);
        rd(8'h14, w);
        chk(w[6:4] == 3'd0, "R11 empty after removal", w[6:4], 0);
        chk(w[2] == 1'b0, "R8 removal from allowed without wake", w[2], 0);

        // R13 / R12: bay 1 independent
        pr1394_n[1] = 1'b0; idle(4);
        rd(8'h20, w);
        chk(w[6:4] == 3'd0, "R9 no move without enable", w[6:4], 0);
        chk(w[2:1] == 2'b11, "R8 bay1 change and 1394", w[2:1], 3);
        chk(alert == 1'b0, "R12 masked change", alert, 0);
        rd(8'h14, w); chk(w[2] == 1'b0, "R13 bay0 untouched", w[2], 0);
        chg_en[1] = 1'b1; idle(1);
        chk(alert == 1'b1, "R12 level after enable", alert, 1);
        wr(8'h14, 32'h4);
        rd(8'h20, w); chk(w[2] == 1'b1, "R13 write to bay0 leaves bay1", w[2], 1);
        wr(8'h20, 32'h4);

        // R10: button on empty bay
        remreq_en[1] = 1'b1; press(1);
        rd(8'h20, w);
        chk(w[3] == 1'b1 && w[6:4] == 3'd0, "R10 empty bay ignores button", w[6:0], 32'h08 | (w[2:0] & 3'b111));
        wr(8'h20, 32'h8);

        // R11: partial removal then full
        prusb_n[1] = 1'b0; idle(4);
        rd(8'h20, w); chk(w[6:4] == 3'd1, "R9 bay1 inserted", w[6:4], 1);
        wr(8'h20, 32'h4);
        pr1394_n[1] = 1'b1; idle(4);
        rd(8'h20, w);
        chk(w[6:4] == 3'd1, "R11 partial removal keeps state", w[6:4], 1);
        chk(w[2] == 1'b1, "R8 partial removal sets change", w[2], 1);
        wr(8'h20, 32'h4);
        prusb_n[1] = 1'b1; idle(4);
        rd(8'h20, w);
        chk(w[6:4] == 3'd0, "R11 last removal empties", w[6:4], 0);

        // R8: removal from allowed with wake enable
        remwake_en[0] = 1'b1; prusb_n[0] = 1'b0; idle(4);
        wr(8'h14, 32'hC); press(0);
        rd(8'h14, w); chk(w[6:4] == 3'd4, "R10 allowed again", w[6:4], 4);
        wr(8'h14, 32'hC);
        prusb_n[0] = 1'b1; idle(4);
        rd(8'h14, w);
        chk(w[2] == 1'b1, "R8 removal with wake enable", w[2], 1);
        chk(w[6:4] == 3'd0, "R11 bay0 empty", w[6:4], 0);

        idle(3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule